// File: doc/BRIEF.md
# Packet Replay Buffer for a Half-Duplex Transmitter

This block sits between a byte-wide AXI4-Stream packet source and a half-duplex Ethernet transmitter. It keeps the start of each packet so that the transmitter can send the packet again after a collision. Every byte handed to the transmitter is read from an internal circular store. There is no bypass path. A rewind request moves the read position back to the first byte of the packet in flight. A release pulse from the transmitter tells the buffer that the packet is finished and that its storage may be reused.

The buffer holds one packet at a time. Once the last byte of a packet is accepted on the input side, the input stalls until the transmitter releases that packet. Collisions in the first `REPLAY_LEN` bytes, which is 56 by default (the slot time less the preamble), can be recovered by a rewind. After that point only a late collision can occur, so rewinds are refused. The storage behind the read position is then freed, which lets packets longer than the store stream through.

Top module: `pkt_replay_buf`

## Requirements
- R1: After reset, `s_axis_tready` is 1 and `m_axis_tvalid` is 0.
- R2: Accepted bytes come out in order. `m_axis_tlast` is 1 on exactly the byte that was accepted with `s_axis_tlast`.
- R3: `s_axis_tready` is a registered look-ahead flag. It falls in the cycle after the acceptance that brings the retained span to DEPTH (2^ADDR_W, 64 by default). No byte is accepted while that span is full.
- R4: After a byte is accepted with `s_axis_tlast`, `s_axis_tready` stays 0 until a release is honoured. It reads 1 in the cycle after that release.
- R5: After the final byte has been taken, `m_axis_tvalid` stays 0 until a release. `pkt_done` is honoured only after the final byte has been taken; earlier pulses have no effect.
- R6: Pulsing `replay_req` while `m_axis_tvalid` is 0 makes the next presented byte the packet's first byte. This holds both mid-packet and after the final byte, provided fewer than REPLAY_LEN bytes have been taken.
- R7: `replay_req` has no effect while `m_axis_tvalid` is 1.
- R8: The storage holding the packet start is not freed until REPLAY_LEN bytes have been taken. When the REPLAY_LEN-th byte is taken, the space behind the read position is freed and `s_axis_tready` may rise again.
- R9: `replay_req` is ignored once REPLAY_LEN bytes of the current packet have been taken.
- R10: While `m_axis_tvalid` is 1 and `m_axis_tready` is 0, `m_axis_tvalid`, `m_axis_tdata` and `m_axis_tlast` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_axis_tdata | input | DATA_W | Input byte |
| s_axis_tvalid | input | 1 | Input byte valid |
| s_axis_tlast | input | 1 | Input byte ends the packet |
| s_axis_tready | output | 1 | Buffer can accept a byte |
| m_axis_tdata | output | DATA_W | Output byte, read from storage |
| m_axis_tvalid | output | 1 | Output byte valid |
| m_axis_tlast | output | 1 | Output byte ends the packet |
| m_axis_tready | input | 1 | Transmitter takes the byte |
| replay_req | input | 1 | Rewind to the packet start |
| pkt_done | input | 1 | Transmitter has finished the packet |

## Verification
The embedded properties check the following on every cycle:
- output stability during back-pressure;
- that no write lands in a full retained span;
- that input is blocked while a finished packet waits for release;
- that the read position sits on the end marker while waiting;
- that refused rewinds leave the read position unchanged.

The directed scenarios cover the rest: byte ordering and the last flag, actual rewinds from both the starved and the finished states, and the early release pulse that must be ignored. They also cover the exact cycle at which the 56th byte read frees space and `s_axis_tready` returns. Pointer wrap-around is reached by running the scenarios one after another.

// File: rtl/pkt_rb_pkg.sv
package pkt_rb_pkg;
  typedef enum logic {
    RD_SEND = 1'b0,
    RD_WAIT = 1'b1
  } rd_state_e;
endpackage

// File: rtl/pkt_rb_mem.sv
module pkt_rb_mem #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ENT_W = DATA_W + 1;

  logic [ENT_W-1:0] ents [DEPTH];

  // One register per entry, no reset: storage content is qualified by pointers.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr == ADDR_W'(i))) begin
        ent_q <= {wr_last, wr_data};
      end
    end
    assign ents[i] = ent_q;
  end

  assign {rd_last, rd_data} = ents[rd_addr];
endmodule

// File: rtl/pkt_rb_wr.sv
module pkt_rb_wr #(
  parameter int ADDR_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid,
  input  logic            s_last,
  input  logic            release_i,
  input  logic [ADDR_W:0] hold_ptr,
  input  logic [ADDR_W:0] hold_ptr_nxt,
  output logic [ADDR_W:0] wr_ptr,
  output logic [ADDR_W:0] end_ptr,
  output logic            wr_en,
  output logic            s_ready
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [PTR_W-1:0] wr_q, wr_d, end_q, end_d;
  logic             end_vld_q, end_vld_d;
  logic             rdy_q, rdy_d;
  logic             acc;

  always_comb begin
    acc       = s_valid && rdy_q;
    wr_d      = wr_q;
    end_d     = end_q;
    end_vld_d = end_vld_q && !release_i;
    if (acc) begin
      wr_d = wr_q + PTR_W'(1);
      if (s_last) begin
        end_d     = wr_q + PTR_W'(1);
        end_vld_d = 1'b1;
      end
    end
    // Look ahead: readiness for the next cycle uses next-state pointers.
    rdy_d = !end_vld_d && ((wr_d - hold_ptr_nxt) != DEPTH_P);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= '0;
      end_q     <= '0;
      end_vld_q <= 1'b0;
      rdy_q     <= 1'b1;
    end else begin
      wr_q      <= wr_d;
      end_q     <= end_d;
      end_vld_q <= end_vld_d;
      rdy_q     <= rdy_d;
    end
  end

  assign wr_ptr  = wr_q;
  assign end_ptr = end_q;
  assign wr_en   = acc;
  assign s_ready = rdy_q;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> ((wr_q - hold_ptr) < DEPTH_P));

  p_block_after_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    end_vld_q |-> !rdy_q);
endmodule

// File: rtl/pkt_rb_rd.sv
module pkt_rb_rd
  import pkt_rb_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int REPLAY_LEN = 56
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADDR_W:0] wr_ptr,
  input  logic [ADDR_W:0] end_ptr,
  input  logic            m_ready,
  input  logic            m_last,
  input  logic            replay,
  input  logic            done,
  output logic [ADDR_W:0] rd_ptr,
  output logic            m_valid,
  output logic            release_o,
  output logic [ADDR_W:0] hold_ptr,
  output logic [ADDR_W:0] hold_ptr_nxt
);
  localparam int PTR_W = ADDR_W + 1;
  localparam logic [PTR_W-1:0] REPLAY_P = PTR_W'(REPLAY_LEN);

  rd_state_e        st_q, st_d;
  logic [PTR_W-1:0] rd_q, rd_d, base_q, base_d;
  logic             past_q, past_d;
  logic             vld, fire, rel;

  always_comb begin
    vld    = (st_q == RD_SEND) && (rd_q != wr_ptr);
    fire   = vld && m_ready;
    st_d   = st_q;
    rd_d   = rd_q;
    base_d = base_q;
    past_d = past_q;
    rel    = 1'b0;
    if (fire) begin
      rd_d = rd_q + PTR_W'(1);
      if (m_last) st_d = RD_WAIT;
    end
    if ((st_q == RD_WAIT) && done) begin
      base_d = end_ptr;
      rd_d   = end_ptr;
      past_d = 1'b0;
      rel    = 1'b1;
      st_d   = RD_SEND;
    end else if (replay && !vld && !past_q) begin
      rd_d = base_q;
      st_d = RD_SEND;
    end
    if (!rel && ((rd_d - base_q) >= REPLAY_P)) past_d = 1'b1;
    hold_ptr_nxt = past_d ? rd_d : base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_SEND;
      rd_q   <= '0;
      base_q <= '0;
      past_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rd_q   <= rd_d;
      base_q <= base_d;
      past_q <= past_d;
    end
  end

  assign rd_ptr    = rd_q;
  assign m_valid   = vld;
  assign release_o = rel;
  assign hold_ptr  = past_q ? rd_q : base_q;

  p_wait_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_WAIT) |-> (rd_q == end_ptr));

  p_replay_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (replay && past_q && !vld) |=> $stable(rd_q));

  p_replay_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (replay && vld && !m_ready) |=> $stable(rd_q));
endmodule

// File: rtl/pkt_replay_buf.sv
module pkt_replay_buf #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int REPLAY_LEN = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] s_axis_tdata,
  input  logic              s_axis_tvalid,
  input  logic              s_axis_tlast,
  output logic              s_axis_tready,
  output logic [DATA_W-1:0] m_axis_tdata,
  output logic              m_axis_tvalid,
  output logic              m_axis_tlast,
  input  logic              m_axis_tready,
  input  logic              replay_req,
  input  logic              pkt_done
);
  localparam int PTR_W = ADDR_W + 1;

  logic [PTR_W-1:0] wr_ptr, end_ptr, rd_ptr, hold_ptr, hold_ptr_nxt;
  logic             wr_en, rel;

  pkt_rb_wr #(.ADDR_W(ADDR_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .s_valid      (s_axis_tvalid),
    .s_last       (s_axis_tlast),
    .release_i    (rel),
    .hold_ptr     (hold_ptr),
    .hold_ptr_nxt (hold_ptr_nxt),
    .wr_ptr       (wr_ptr),
    .end_ptr      (end_ptr),
    .wr_en        (wr_en),
    .s_ready      (s_axis_tready)
  );

  pkt_rb_rd #(.ADDR_W(ADDR_W), .REPLAY_LEN(REPLAY_LEN)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ptr       (wr_ptr),
    .end_ptr      (end_ptr),
    .m_ready      (m_axis_tready),
    .m_last       (m_axis_tlast),
    .replay       (replay_req),
    .done         (pkt_done),
    .rd_ptr       (rd_ptr),
    .m_valid      (m_axis_tvalid),
    .release_o    (rel),
    .hold_ptr     (hold_ptr),
    .hold_ptr_nxt (hold_ptr_nxt)
  );

  pkt_rb_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_ptr[ADDR_W-1:0]),
    .wr_data (s_axis_tdata),
    .wr_last (s_axis_tlast),
    .rd_addr (rd_ptr[ADDR_W-1:0]),
    .rd_data (m_axis_tdata),
    .rd_last (m_axis_tlast)
  );

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_axis_tvalid && !m_axis_tready) |=>
      (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));

  p_rd_behind_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr - rd_ptr) <= PTR_W'(1 << ADDR_W));
endmodule

// File: tb/pkt_replay_buf_tb.sv
`timescale 1ns/1ps
module pkt_replay_buf_tb;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 6;
  localparam int RLEN   = 56;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] s_data = '0;
  logic              s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [DATA_W-1:0] m_data;
  logic              m_valid, m_last;
  logic              m_ready = 1'b0, replay = 1'b0, done = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pkt_replay_buf #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REPLAY_LEN(RLEN)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_axis_tdata(s_data), .s_axis_tvalid(s_valid), .s_axis_tlast(s_last),
    .s_axis_tready(s_ready),
    .m_axis_tdata(m_data), .m_axis_tvalid(m_valid), .m_axis_tlast(m_last),
    .m_axis_tready(m_ready), .replay_req(replay), .pkt_done(done)
  );

  function automatic logic [7:0] pb(input int p, input int k);
    return 8'((p * 16 + k) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic l);
    logic ok;
    s_data = d; s_last = l; s_valid = 1'b1;
    forever begin
      ok = s_ready;
      @(negedge clk);
      if (ok) break;
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic pop(input logic [7:0] ed, input logic el, input string req);
    int w = 0;
    while (!m_valid && w < 50) begin @(negedge clk); w++; end
    check({req, " valid"}, int'(m_valid), 1);
    check({req, " data"}, int'(m_data), int'(ed));
    check({req, " last"}, int'(m_last), int'(el));
    m_ready = 1'b1;
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1; @(negedge clk); done = 1'b0;
  endtask

  task automatic pulse_replay();
    replay = 1'b1; @(negedge clk); replay = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready", int'(s_ready), 1);
    check("R1 valid", int'(m_valid), 0);
  endtask

  task automatic t_basic();
    for (int k = 0; k < 10; k++) push(pb(1, k), k == 9);
    check("R4 ready low after last", int'(s_ready), 0);
    for (int k = 0; k < 10; k++) pop(pb(1, k), k == 9, "R2 basic");
    check("R5 valid low after final", int'(m_valid), 0);
    pulse_done();
    check("R4 ready after release", int'(s_ready), 1);
  endtask

  task automatic t_replay_short();
    for (int k = 0; k < 5; k++) push(pb(2, k), k == 4);
    for (int k = 0; k < 5; k++) pop(pb(2, k), k == 4, "R2 short");
    check("R5 waiting", int'(m_valid), 0);
    pulse_replay();
    for (int k = 0; k < 5; k++) pop(pb(2, k), k == 4, "R6 replay after final");
    pulse_done();
  endtask

  task automatic t_replay_starved();
    for (int k = 0; k < 3; k++) push(pb(3, k), 1'b0);
    for (int k = 0; k < 3; k++) pop(pb(3, k), 1'b0, "R2 partial");
    check("R6 starved", int'(m_valid), 0);
    pulse_replay();
    check("R6 rewound valid", int'(m_valid), 1);
    check("R6 rewound data", int'(m_data), int'(pb(3, 0)));
    for (int k = 3; k < 6; k++) push(pb(3, k), k == 5);
    for (int k = 0; k < 6; k++) pop(pb(3, k), k == 5, "R6 resend");
    pulse_done();
  endtask

  task automatic t_replay_busy();
    for (int k = 0; k < 4; k++) push(pb(4, k), k == 3);
    pop(pb(4, 0), 1'b0, "R2 first");
    pulse_replay();
    check("R10 valid held", int'(m_valid), 1);
    check("R7 data unchanged", int'(m_data), int'(pb(4, 1)));
    @(negedge clk);
    check("R10 data held", int'(m_data), int'(pb(4, 1)));
    for (int k = 1; k < 4; k++) pop(pb(4, k), k == 3, "R7 continue");
    pulse_done();
  endtask

  task automatic t_early_done();
    for (int k = 0; k < 3; k++) push(pb(5, k), k == 2);
    pop(pb(5, 0), 1'b0, "R2 early");
    pulse_done();
    check("R5 early done ignored ready", int'(s_ready), 0);
    for (int k = 1; k < 3; k++) pop(pb(5, k), k == 2, "R5 early done ignored");
    pulse_done();
    check("R4 ready after release", int'(s_ready), 1);
  endtask

  task automatic t_full_window();
    for (int k = 0; k < 63; k++) push(pb(6, k), 1'b0);
    check("R3 ready before full", int'(s_ready), 1);
    push(pb(6, 63), 1'b0);
    check("R3 ready low when full", int'(s_ready), 0);
    s_data = pb(6, 99); s_valid = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    for (int k = 0; k < RLEN - 1; k++) pop(pb(6, k), 1'b0, "R2 long");
    check("R8 start retained", int'(s_ready), 0);
    pop(pb(6, RLEN - 1), 1'b0, "R2 long");
    check("R8 freed at window", int'(s_ready), 1);
    for (int k = RLEN; k < 64; k++) pop(pb(6, k), 1'b0, "R3 no extra byte");
    check("R3 drained", int'(m_valid), 0);
    pulse_replay();
    check("R9 replay ignored", int'(m_valid), 0);
    push(pb(6, 64), 1'b1);
    pop(pb(6, 64), 1'b1, "R9 continues");
    pulse_done();
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_replay_short();
    t_replay_starved();
    t_replay_busy();
    t_early_done();
    t_full_window();
    t_basic();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule